// File: doc/BRIEF.md
# Store Set Dependence Predictor

This block predicts, for each memory instruction entering an out-of-order core, which older in-flight store it should wait for. It holds two tables. The set table is indexed by a hash of the instruction address and maps it to a store set identifier, with a valid bit per entry. The last-store table is indexed by that identifier and holds the sequence number of the most recently fetched store belonging to the set, also with a valid bit. When a load is found to have run ahead of a store it depended on, the pair is trained into a common set. Fetched stores then publish their sequence numbers, and later loads or stores in the same set read them back as their predicted producer.

Every port is a single-cycle, valid-qualified command that the block always accepts. There is no back-pressure: a command presented with its valid high on a rising clock edge takes effect on that edge. The lookup port is purely combinational from the registered tables and has no valid at all. A returned sequence number of 0 means "no predicted dependence", so the feeding logic must never use 0 as the sequence number of a real store. The set table depth and the last-store table depth must both be powers of two, and the last-store table must be no deeper than the set table.

Top module: `store_set_predictor`

## Requirements
- R1: After reset, every valid bit in both tables is 0, so a lookup of any address returns 0.
- R2: The set table index is the address shifted right by 2 and masked to the table size. Addresses that differ only in bits 1:0 or above the index field reach the same entry.
- R3: In a training event where neither the load's nor the store's entry is valid, both entries become valid. Both receive a new identifier, equal to the load's set-table index taken modulo the last-store table depth.
- R4: In a training event where exactly one of the two entries is valid, its identifier is copied into the other entry, which becomes valid.
- R5: In a training event where both entries are valid, the numerically smaller identifier is kept. Only the entry holding the larger one is overwritten; if the two are equal, nothing changes.
- R6: A store insert whose set-table entry is invalid changes nothing. Otherwise it writes its sequence number into the last-store entry of its set and marks that entry valid.
- R7: A lookup returns 0 when the address's set-table entry is invalid, or when its set's last-store entry is invalid. Otherwise it returns the stored sequence number.
- R8: A store issue invalidates its set's last-store entry only when that entry is valid and holds exactly the issuing sequence number. An issue with the store flag low has no effect.
- R9: A squash with sequence number N invalidates every valid last-store entry whose sequence number is greater than N (unsigned compare); entries at or below N stay valid.
- R10: A clear drops every valid bit in both tables on the next edge and overrides any other command presented in the same cycle.
- R11: Within one cycle, updates are applied in this order: training first, then insert, then store issue, then squash. Insert and issue see the set table as already trained, and issue and squash see the insert's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Global clear of all valid bits |
| viol_vld | input | 1 | Training event present |
| viol_load_pc | input | PC_W | Address of the load that ran too early |
| viol_store_pc | input | PC_W | Address of the store it conflicted with |
| ins_vld | input | 1 | Store fetched this cycle |
| ins_pc | input | PC_W | Address of the fetched store |
| ins_seq | input | SEQ_W | Sequence number of the fetched store |
| iss_vld | input | 1 | Memory instruction issued this cycle |
| iss_is_store | input | 1 | Issued instruction is a store |
| iss_pc | input | PC_W | Address of the issued instruction |
| iss_seq | input | SEQ_W | Sequence number of the issued instruction |
| sq_vld | input | 1 | Squash this cycle |
| sq_seq | input | SEQ_W | Youngest surviving sequence number |
| look_pc | input | PC_W | Address to predict for |
| look_seq | output | SEQ_W | Predicted producer store, 0 for none |

## Verification
The bench builds the block with a 16-bit address, a 16-entry set table and a 4-entry last-store table. Because fresh identifiers are the load index modulo 4, unrelated training events collide in the same set, so set merging and shared last-store entries occur constantly. Random addresses vary every bit, which drives the aliasing of R2 through both the low two bits and the bits above the index. Sequence numbers drawn from 1 to 63 make exact issue matches and squash boundaries frequent rather than rare.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  // Which of the four training cases a violation falls into
  typedef enum logic [1:0] {
    TRN_FRESH    = 2'd0,  // neither side owns a set
    TRN_TO_STORE = 2'd1,  // load side owns a set, store joins it
    TRN_TO_LOAD  = 2'd2,  // store side owns a set, load joins it
    TRN_MERGE    = 2'd3   // both own sets, lower identifier survives
  } trn_kind_e;

  localparam int unsigned ADDR_LSB = 2;

endpackage

// File: rtl/ssp_train.sv
module ssp_train
  import ssp_pkg::*;
#(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned SID_W = 7
) (
  input  logic             ld_vld,
  input  logic [SID_W-1:0] ld_sid,
  input  logic             st_vld,
  input  logic [SID_W-1:0] st_sid,
  input  logic [IDX_W-1:0] ld_idx,
  output trn_kind_e        kind,
  output logic             ld_we,
  output logic [SID_W-1:0] ld_wid,
  output logic             st_we,
  output logic [SID_W-1:0] st_wid
);

  logic [SID_W-1:0] fresh_sid;

  // new identifier: low bits of the load index (modulo set count)
  assign fresh_sid = ld_idx[SID_W-1:0];

  always_comb begin
    unique case ({ld_vld, st_vld})
      2'b00:   kind = TRN_FRESH;
      2'b10:   kind = TRN_TO_STORE;
      2'b01:   kind = TRN_TO_LOAD;
      default: kind = TRN_MERGE;
    endcase
  end

  always_comb begin
    ld_we  = 1'b0;
    st_we  = 1'b0;
    ld_wid = '0;
    st_wid = '0;
    unique case (kind)
      TRN_FRESH: begin
        ld_we  = 1'b1;
        st_we  = 1'b1;
        ld_wid = fresh_sid;
        st_wid = fresh_sid;
      end
      TRN_TO_STORE: begin
        st_we  = 1'b1;
        st_wid = ld_sid;
      end
      TRN_TO_LOAD: begin
        ld_we  = 1'b1;
        ld_wid = st_sid;
      end
      default: begin
        if (st_sid > ld_sid) begin
          st_we  = 1'b1;
          st_wid = ld_sid;
        end else if (ld_sid > st_sid) begin
          ld_we  = 1'b1;
          ld_wid = st_sid;
        end
      end
    endcase
  end

endmodule

// File: rtl/ssp_set_table.sv
module ssp_set_table #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned SID_W = 7,
  parameter int unsigned N_RD  = 3,
  parameter int unsigned N_FW  = 2,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  // two write ports from training
  input  logic                       wa_en,
  input  logic [IDX_W-1:0]           wa_idx,
  input  logic [SID_W-1:0]           wa_sid,
  input  logic                       wb_en,
  input  logic [IDX_W-1:0]           wb_idx,
  input  logic [SID_W-1:0]           wb_sid,
  // reads of the registered state
  input  logic [N_RD-1:0][IDX_W-1:0] rd_idx,
  output logic [N_RD-1:0]            rd_vld,
  output logic [N_RD-1:0][SID_W-1:0] rd_sid,
  // reads of the state after this cycle's training
  input  logic [N_FW-1:0][IDX_W-1:0] fw_idx,
  output logic [N_FW-1:0]            fw_vld,
  output logic [N_FW-1:0][SID_W-1:0] fw_sid,
  // whole-table view
  output logic [DEPTH-1:0]            vld_o,
  output logic [DEPTH-1:0][SID_W-1:0] sid_o
);

  logic [DEPTH-1:0]            vld_q, vld_n;
  logic [DEPTH-1:0][SID_W-1:0] sid_q, sid_n;

  always_comb begin
    vld_n = vld_q;
    sid_n = sid_q;
    if (clr) begin
      vld_n = '0;
    end else begin
      if (wa_en) begin
        vld_n[wa_idx] = 1'b1;
        sid_n[wa_idx] = wa_sid;
      end
      if (wb_en) begin
        vld_n[wb_idx] = 1'b1;
        sid_n[wb_idx] = wb_sid;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      sid_q <= '0;
    end else begin
      vld_q <= vld_n;
      sid_q <= sid_n;
    end
  end

  for (genvar g = 0; g < N_RD; g++) begin : g_rd
    assign rd_vld[g] = vld_q[rd_idx[g]];
    assign rd_sid[g] = sid_q[rd_idx[g]];
  end

  for (genvar g = 0; g < N_FW; g++) begin : g_fw
    assign fw_vld[g] = vld_n[fw_idx[g]];
    assign fw_sid[g] = sid_n[fw_idx[g]];
  end

  assign vld_o = vld_q;
  assign sid_o = sid_q;

endmodule

// File: rtl/ssp_last_store.sv
module ssp_last_store #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned SEQ_W = 16,
  localparam int unsigned SID_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ins_en,
  input  logic [SID_W-1:0] ins_sid,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic             iss_en,
  input  logic [SID_W-1:0] iss_sid,
  input  logic [SEQ_W-1:0] iss_seq,
  input  logic             sq_en,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic [SID_W-1:0] rd_sid,
  output logic             rd_vld,
  output logic [SEQ_W-1:0] rd_seq
);

  logic [DEPTH-1:0]            vld_q;
  logic [DEPTH-1:0][SEQ_W-1:0] seq_q;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic             v_ins, v_iss, v_sq;
    logic [SEQ_W-1:0] s_ins;
    logic             hit_ins, hit_iss;

    assign hit_ins = ins_en && (ins_sid == SID_W'(e));
    assign hit_iss = iss_en && (iss_sid == SID_W'(e));

    // insert, then issue, then squash: each stage sees the previous one
    always_comb begin
      v_ins = vld_q[e];
      s_ins = seq_q[e];
      if (hit_ins) begin
        v_ins = 1'b1;
        s_ins = ins_seq;
      end
      v_iss = v_ins;
      if (hit_iss && v_ins && (s_ins == iss_seq)) begin
        v_iss = 1'b0;
      end
      v_sq = v_iss;
      if (sq_en && v_iss && (s_ins > sq_seq)) begin
        v_sq = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[e] <= 1'b0;
        seq_q[e] <= '0;
      end else if (clr) begin
        vld_q[e] <= 1'b0;
      end else begin
        vld_q[e] <= v_sq;
        seq_q[e] <= s_ins;
      end
    end
  end

  assign rd_vld = vld_q[rd_sid];
  assign rd_seq = seq_q[rd_sid];

endmodule

// File: rtl/store_set_predictor.sv
module store_set_predictor
  import ssp_pkg::*;
#(
  parameter int unsigned PC_W        = 32,
  parameter int unsigned SSIT_DEPTH  = 1024,
  parameter int unsigned LFST_DEPTH  = 128,
  parameter int unsigned SEQ_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             viol_vld,
  input  logic [PC_W-1:0]  viol_load_pc,
  input  logic [PC_W-1:0]  viol_store_pc,
  input  logic             ins_vld,
  input  logic [PC_W-1:0]  ins_pc,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic             iss_vld,
  input  logic             iss_is_store,
  input  logic [PC_W-1:0]  iss_pc,
  input  logic [SEQ_W-1:0] iss_seq,
  input  logic             sq_vld,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic [PC_W-1:0]  look_pc,
  output logic [SEQ_W-1:0] look_seq
);

  localparam int unsigned IDX_W = $clog2(SSIT_DEPTH);
  localparam int unsigned SID_W = $clog2(LFST_DEPTH);
  localparam int unsigned N_RD  = 3;
  localparam int unsigned N_FW  = 2;
  localparam int unsigned RD_LD = 0;
  localparam int unsigned RD_ST = 1;
  localparam int unsigned RD_LK = 2;
  localparam int unsigned FW_IN = 0;
  localparam int unsigned FW_IS = 1;

  logic [IDX_W-1:0] ld_idx, st_idx, ins_idx, iss_idx, look_idx;

  assign ld_idx   = viol_load_pc [ADDR_LSB +: IDX_W];
  assign st_idx   = viol_store_pc[ADDR_LSB +: IDX_W];
  assign ins_idx  = ins_pc       [ADDR_LSB +: IDX_W];
  assign iss_idx  = iss_pc       [ADDR_LSB +: IDX_W];
  assign look_idx = look_pc      [ADDR_LSB +: IDX_W];

  logic [N_RD-1:0][IDX_W-1:0] rd_idx;
  logic [N_RD-1:0]            rd_vld;
  logic [N_RD-1:0][SID_W-1:0] rd_sid;
  logic [N_FW-1:0][IDX_W-1:0] fw_idx;
  logic [N_FW-1:0]            fw_vld;
  logic [N_FW-1:0][SID_W-1:0] fw_sid;
  logic [SSIT_DEPTH-1:0]            ssit_vld;
  logic [SSIT_DEPTH-1:0][SID_W-1:0] ssit_sid;

  always_comb begin
    rd_idx        = '0;
    rd_idx[RD_LD] = ld_idx;
    rd_idx[RD_ST] = st_idx;
    rd_idx[RD_LK] = look_idx;
    fw_idx        = '0;
    fw_idx[FW_IN] = ins_idx;
    fw_idx[FW_IS] = iss_idx;
  end

  // training decision
  trn_kind_e        trn_kind;
  logic             ld_we, st_we;
  logic [SID_W-1:0] ld_wid, st_wid;

  ssp_train #(
    .IDX_W (IDX_W),
    .SID_W (SID_W)
  ) u_train (
    .ld_vld (rd_vld[RD_LD]),
    .ld_sid (rd_sid[RD_LD]),
    .st_vld (rd_vld[RD_ST]),
    .st_sid (rd_sid[RD_ST]),
    .ld_idx (ld_idx),
    .kind   (trn_kind),
    .ld_we  (ld_we),
    .ld_wid (ld_wid),
    .st_we  (st_we),
    .st_wid (st_wid)
  );

  ssp_set_table #(
    .DEPTH (SSIT_DEPTH),
    .SID_W (SID_W),
    .N_RD  (N_RD),
    .N_FW  (N_FW)
  ) u_sets (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .wa_en  (viol_vld && ld_we),
    .wa_idx (ld_idx),
    .wa_sid (ld_wid),
    .wb_en  (viol_vld && st_we),
    .wb_idx (st_idx),
    .wb_sid (st_wid),
    .rd_idx (rd_idx),
    .rd_vld (rd_vld),
    .rd_sid (rd_sid),
    .fw_idx (fw_idx),
    .fw_vld (fw_vld),
    .fw_sid (fw_sid),
    .vld_o  (ssit_vld),
    .sid_o  (ssit_sid)
  );

  // commands reaching the last-store table
  logic ins_hit, iss_hit;
  logic ins_en, iss_en, sq_en;

  assign ins_hit = fw_vld[FW_IN];
  assign iss_hit = fw_vld[FW_IS];
  assign ins_en  = ins_vld && ins_hit && !clr;
  assign iss_en  = iss_vld && iss_is_store && iss_hit && !clr;
  assign sq_en   = sq_vld && !clr;

  logic             lf_vld;
  logic [SEQ_W-1:0] lf_seq;

  ssp_last_store #(
    .DEPTH (LFST_DEPTH),
    .SEQ_W (SEQ_W)
  ) u_last (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .ins_en  (ins_en),
    .ins_sid (fw_sid[FW_IN]),
    .ins_seq (ins_seq),
    .iss_en  (iss_en),
    .iss_sid (fw_sid[FW_IS]),
    .iss_seq (iss_seq),
    .sq_en   (sq_en),
    .sq_seq  (sq_seq),
    .rd_sid  (rd_sid[RD_LK]),
    .rd_vld  (lf_vld),
    .rd_seq  (lf_seq)
  );

  assign look_seq = (rd_vld[RD_LK] && lf_vld) ? lf_seq : '0;

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned SSIT_DEPTH = 1024,
  parameter int unsigned SID_W      = 7,
  parameter int unsigned SEQ_W      = 16,
  localparam int unsigned IDX_W     = $clog2(SSIT_DEPTH)
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            clr,
  input logic                            viol_vld,
  input logic [IDX_W-1:0]                ld_idx,
  input logic [IDX_W-1:0]                st_idx,
  input logic [SSIT_DEPTH-1:0]           ssit_vld,
  input logic [SSIT_DEPTH-1:0][SID_W-1:0] ssit_sid,
  input logic [IDX_W-1:0]                look_idx,
  input logic [PC_W-1:0]                 look_pc,
  input logic [SEQ_W-1:0]                look_seq,
  input logic                            ins_vld,
  input logic                            ins_hit,
  input logic [PC_W-1:0]                 ins_pc,
  input logic [SEQ_W-1:0]                ins_seq,
  input logic                            iss_vld,
  input logic                            iss_is_store,
  input logic                            sq_vld,
  input logic [SEQ_W-1:0]                sq_seq
);

  // R10: a clear leaves nothing to predict
  p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> look_seq == '0);

  // R3/R4: after training both sides are valid and share one identifier
  p_pair_joined_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_vld && !clr) |=>
      (ssit_vld[$past(ld_idx)] && ssit_vld[$past(st_idx)] &&
       ssit_sid[$past(ld_idx)] == ssit_sid[$past(st_idx)]));

  // R5: merging keeps the smaller identifier
  p_lower_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_vld && !clr && ssit_vld[ld_idx] && ssit_vld[st_idx]) |=>
      (ssit_sid[$past(ld_idx)] ==
        (($past(ssit_sid[ld_idx]) < $past(ssit_sid[st_idx])) ?
          $past(ssit_sid[ld_idx]) : $past(ssit_sid[st_idx]))));

  // R7: no set, no prediction
  p_lookup_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ssit_vld[look_idx] |-> look_seq == '0);

  // R9: nothing younger than the squash point survives
  p_squash_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_vld && !clr) |=> look_seq <= $past(sq_seq));

  // R6: an accepted insert is visible on the next cycle
  p_insert_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_vld && ins_hit && !clr && !sq_vld && !(iss_vld && iss_is_store)) |=>
      (look_pc != $past(ins_pc) || look_seq == $past(ins_seq)));

endmodule

bind store_set_predictor ssp_checker #(
  .PC_W       (PC_W),
  .SSIT_DEPTH (SSIT_DEPTH),
  .SID_W      (SID_W),
  .SEQ_W      (SEQ_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .clr          (clr),
  .viol_vld     (viol_vld),
  .ld_idx       (ld_idx),
  .st_idx       (st_idx),
  .ssit_vld     (ssit_vld),
  .ssit_sid     (ssit_sid),
  .look_idx     (look_idx),
  .look_pc      (look_pc),
  .look_seq     (look_seq),
  .ins_vld      (ins_vld),
  .ins_hit      (ins_hit),
  .ins_pc       (ins_pc),
  .ins_seq      (ins_seq),
  .iss_vld      (iss_vld),
  .iss_is_store (iss_is_store),
  .sq_vld       (sq_vld),
  .sq_seq       (sq_seq)
);

// File: tb/store_set_predictor_bench.sv
`timescale 1ns/1ps
module store_set_predictor_bench;

  localparam int PC_W = 16;
  localparam int SSIT = 16;
  localparam int LFST = 4;
  localparam int SEQ_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             clr;
  logic             viol_vld;
  logic [PC_W-1:0]  viol_load_pc, viol_store_pc;
  logic             ins_vld;
  logic [PC_W-1:0]  ins_pc;
  logic [SEQ_W-1:0] ins_seq;
  logic             iss_vld, iss_is_store;
  logic [PC_W-1:0]  iss_pc;
  logic [SEQ_W-1:0] iss_seq;
  logic             sq_vld;
  logic [SEQ_W-1:0] sq_seq;
  logic [PC_W-1:0]  look_pc;
  logic [SEQ_W-1:0] look_seq;

  always #4 clk = ~clk;

  store_set_predictor #(
    .PC_W (PC_W), .SSIT_DEPTH (SSIT), .LFST_DEPTH (LFST), .SEQ_W (SEQ_W)
  ) u_store_set_predictor (
    .clk (clk), .rst_n (rst_n), .clr (clr),
    .viol_vld (viol_vld), .viol_load_pc (viol_load_pc), .viol_store_pc (viol_store_pc),
    .ins_vld (ins_vld), .ins_pc (ins_pc), .ins_seq (ins_seq),
    .iss_vld (iss_vld), .iss_is_store (iss_is_store), .iss_pc (iss_pc), .iss_seq (iss_seq),
    .sq_vld (sq_vld), .sq_seq (sq_seq),
    .look_pc (look_pc), .look_seq (look_seq)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  bit m_sv [SSIT];
  int m_sid[SSIT];
  bit m_lv [LFST];
  int m_lsq[LFST];

  function automatic int mi(logic [PC_W-1:0] pc);
    return int'((pc >> 2) & (SSIT - 1));
  endfunction

  function automatic int m_look(logic [PC_W-1:0] pc);
    int i = mi(pc);
    if (!m_sv[i]) return 0;
    if (!m_lv[m_sid[i]]) return 0;
    return m_lsq[m_sid[i]];
  endfunction

  function automatic logic [PC_W-1:0] pa(int i);
    return PC_W'(i << 2);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < SSIT; i++) begin m_sv[i] = 0; m_sid[i] = 0; end
    for (int i = 0; i < LFST; i++) begin m_lv[i] = 0; m_lsq[i] = 0; end
  endtask

  task automatic model_tick();
    int li, si, k;
    if (clr) begin
      model_reset();
      return;
    end
    if (viol_vld) begin
      li = mi(viol_load_pc);
      si = mi(viol_store_pc);
      if (!m_sv[li] && !m_sv[si]) begin
        m_sv[li] = 1; m_sid[li] = li % LFST;
        m_sv[si] = 1; m_sid[si] = li % LFST;
      end else if (m_sv[li] && !m_sv[si]) begin
        m_sv[si] = 1; m_sid[si] = m_sid[li];
      end else if (!m_sv[li] && m_sv[si]) begin
        m_sv[li] = 1; m_sid[li] = m_sid[si];
      end else if (m_sid[si] > m_sid[li]) begin
        m_sid[si] = m_sid[li];
      end else begin
        m_sid[li] = m_sid[si];
      end
    end
    if (ins_vld && m_sv[mi(ins_pc)]) begin
      k = m_sid[mi(ins_pc)];
      m_lv[k] = 1; m_lsq[k] = int'(ins_seq);
    end
    if (iss_vld && iss_is_store && m_sv[mi(iss_pc)]) begin
      k = m_sid[mi(iss_pc)];
      if (m_lv[k] && m_lsq[k] == int'(iss_seq)) m_lv[k] = 0;
    end
    if (sq_vld) begin
      for (int e = 0; e < LFST; e++)
        if (m_lv[e] && m_lsq[e] > int'(sq_seq)) m_lv[e] = 0;
    end
  endtask

  task automatic idle();
    clr = 0; viol_vld = 0; viol_load_pc = '0; viol_store_pc = '0;
    ins_vld = 0; ins_pc = '0; ins_seq = '0;
    iss_vld = 0; iss_is_store = 0; iss_pc = '0; iss_seq = '0;
    sq_vld = 0; sq_seq = '0;
  endtask

  task automatic tick();
    model_tick();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: look_seq actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic look(string tag, logic [PC_W-1:0] pc, int exp);
    look_pc = pc;
    #1;
    check(tag, int'(look_seq), exp);
    check(tag, int'(look_seq), m_look(pc));
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #1200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    idle();
    look_pc = '0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    look("R1", pa(3), 0);
    look("R1", pa(15), 0);

    // R6: insert with no set does nothing
    ins_vld = 1; ins_pc = pa(5); ins_seq = 10; tick();
    look("R6", pa(5), 0);

    // R3: fresh set, id = 6 mod 4 = 2
    viol_vld = 1; viol_load_pc = pa(6); viol_store_pc = pa(9); tick();
    ins_vld = 1; ins_pc = pa(9); ins_seq = 20; tick();
    look("R3", pa(6), 20);
    look("R7", pa(9), 20);

    // R2: aliasing through low bits and bits above the index
    look("R2", pa(6) | 16'h0003 | 16'h0040, 20);
    look("R2", pa(6) | 16'h8000, 20);

    // R4: load side joins the store's set
    viol_vld = 1; viol_load_pc = pa(1); viol_store_pc = pa(9); tick();
    look("R4", pa(1), 20);

    // R5: merge, set 2 beats set 3
    viol_vld = 1; viol_load_pc = pa(7); viol_store_pc = pa(12); tick();
    ins_vld = 1; ins_pc = pa(12); ins_seq = 30; tick();
    look("R3", pa(7), 30);
    viol_vld = 1; viol_load_pc = pa(6); viol_store_pc = pa(12); tick();
    ins_vld = 1; ins_pc = pa(12); ins_seq = 40; tick();
    look("R5", pa(6), 40);
    look("R5", pa(7), 30);

    // R8: mismatching issue, load issue, matching issue
    iss_vld = 1; iss_is_store = 1; iss_pc = pa(12); iss_seq = 39; tick();
    look("R8", pa(6), 40);
    iss_vld = 1; iss_is_store = 0; iss_pc = pa(12); iss_seq = 40; tick();
    look("R8", pa(6), 40);
    iss_vld = 1; iss_is_store = 1; iss_pc = pa(12); iss_seq = 40; tick();
    look("R8", pa(6), 0);

    // R9: squash boundary
    ins_vld = 1; ins_pc = pa(12); ins_seq = 50; tick();
    ins_vld = 1; ins_pc = pa(7); ins_seq = 60; tick();
    sq_vld = 1; sq_seq = 55; tick();
    look("R9", pa(6), 50);
    look("R9", pa(7), 0);
    sq_vld = 1; sq_seq = 50; tick();
    look("R9", pa(6), 50);

    // R11: same-cycle ordering
    viol_vld = 1; viol_load_pc = pa(2); viol_store_pc = pa(13);
    ins_vld = 1; ins_pc = pa(13); ins_seq = 70; tick();
    look("R11", pa(2), 70);
    ins_vld = 1; ins_pc = pa(13); ins_seq = 71;
    iss_vld = 1; iss_is_store = 1; iss_pc = pa(13); iss_seq = 71; tick();
    look("R11", pa(2), 0);
    ins_vld = 1; ins_pc = pa(13); ins_seq = 90; sq_vld = 1; sq_seq = 80; tick();
    look("R11", pa(2), 0);

    // R10: clear wins over a same-cycle insert
    ins_vld = 1; ins_pc = pa(12); ins_seq = 45; clr = 1; tick();
    look("R10", pa(6), 0);
    ins_vld = 1; ins_pc = pa(12); ins_seq = 5; tick();
    look("R10", pa(12), 0);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      viol_vld      = ($urandom % 8) == 0;
      viol_load_pc  = PC_W'($urandom);
      viol_store_pc = PC_W'($urandom);
      ins_vld       = ($urandom % 3) == 0;
      ins_pc        = PC_W'($urandom);
      ins_seq       = SEQ_W'(1 + $urandom % 63);
      iss_vld       = ($urandom % 4) == 0;
      iss_is_store  = ($urandom % 4) != 0;
      iss_pc        = PC_W'($urandom);
      iss_seq       = SEQ_W'(1 + $urandom % 63);
      sq_vld        = ($urandom % 16) == 0;
      sq_seq        = SEQ_W'($urandom % 64);
      clr           = ($urandom % 200) == 0;
      look_pc       = PC_W'($urandom);
      #1;
      check("R7", int'(look_seq), m_look(look_pc));
      model_tick();
      @(posedge clk);
      @(negedge clk);
    end
    idle();

    report();
    $finish;
  end

endmodule